// File: doc/BRIEF.md
# Slice Chop and Dither Removal Path

This block sits in one slice of a time-interleaved converter, directly after the stage that combines the pipeline bits into a binary word. In the analog domain, the slice input was multiplied by a pseudo-random sign and a known pseudo-random dither was added to it. The block produces the same two pseudo-random streams. It sends a leading copy of them to the analog injection circuit. It uses a delay-matched copy to undo both effects on each returned sample: it subtracts the dither, applies a signed offset trim, restores the sign, and scales the result by an unsigned gain trim with rounding and saturation.

The block also accumulates two correlations over a fixed window of samples for an external background loop. The first is the plain sum of the pre-unchop residual, which the chopping turns into an offset estimate for any input signal. The second is the sum of the residual multiplied by the dither, which gives a gain error against the absolute dither reference. At the end of each window both sums are latched and a one-cycle strobe is raised.

Top module: `slice_unchop_corrector`

## Requirements
- R1: Each stream comes from a 15-bit shift generator. On each step the state shifts left by one, and the new bit 0 is state bit 14 XOR state bit 13. The sign stream starts at parameter CHOP_SEED and the dither stream at DITH_SEED. The sign for a sample is bit 0 of the sign state, where 1 means inverted. The dither is the low DITH_W bits of the dither state, read as a signed value. The k-th accepted sample after reset (counting from 0) uses the states reached after k steps.
- R2: `inj_chop` and `inj_dither` show the values that the alignment copy will use LEAD samples later.
- R3: For an accepted sample x, let t = x - dither + offset_trim. The output is round((sign ? -t : t) * gain_trim / 2^15), where gain_trim is unsigned with 15 fraction bits (0x8000 = 1.0). Rounding adds 2^14 and then floors.
- R4: A result outside the signed OUT_W range is clamped to the largest or smallest representable value.
- R5: `out_valid` rises exactly 3 cycles after an `in_valid` cycle. Cycles without `in_valid` do not advance either stream.
- R6: Over each window of 2^ACC_LOG accepted samples, `corr_offset` latches the sum of t and `corr_gain` latches the sum of dither*t. `corr_done` is high for one cycle just after the latch, and the sums restart at zero for the next window.
- R7: During reset, `out_valid` and `corr_done` are 0, both correlation results are 0, and the leading streams restart from the seeds advanced LEAD steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | IN_W | Signed combined slice word |
| offset_trim | input | OFF_W | Signed offset correction, added before the sign is restored |
| gain_trim | input | GAIN_W | Unsigned gain, 15 fraction bits |
| inj_chop | output | 1 | Sign bit for the analog chopper |
| inj_dither | output | DITH_W | Signed dither code for the injection DAC |
| out_valid | output | 1 | Corrected sample present |
| out_sample | output | OUT_W | Signed corrected sample |
| corr_done | output | 1 | Window finished, results latched |
| corr_offset | output | IN_W+2+ACC_LOG | Signed residual sum over the window |
| corr_gain | output | IN_W+2+DITH_W+ACC_LOG | Signed residual-times-dither sum |

## Verification
The bench builds the block with ACC_LOG = 6, which makes a correlation window 64 samples long. This lets a full window, its latch and the strobe be checked against sums kept in the bench. LEAD = 3 separates the injection streams from the alignment copy by more than one step, so a wrong lead count shows up. With DITH_W = 10 and a 16-bit input, the dither is large enough to change the residual visibly, while the headroom still allows gains near 2.0 that drive the saturation corners.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  localparam int PRBS_W = 15;

  function automatic logic [PRBS_W-1:0] prbs_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[14] ^ s[13]};
  endfunction

  function automatic logic [PRBS_W-1:0] prbs_advance(input logic [PRBS_W-1:0] s, input int n);
    logic [PRBS_W-1:0] r;
    r = s;
    for (int i = 0; i < n; i++) r = prbs_step(r);
    return r;
  endfunction
endpackage

// File: rtl/cdr_prbs.sv
module cdr_prbs
  import cdr_pkg::*;
#(
  parameter logic [PRBS_W-1:0] SEED = 15'h1ACE,
  parameter int LEAD     = 2,
  parameter int OUT_BITS = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  output logic [OUT_BITS-1:0] align_bits,
  output logic [OUT_BITS-1:0] lead_bits
);
  localparam logic [PRBS_W-1:0] LEAD_SEED = prbs_advance(SEED, LEAD);

  logic [PRBS_W-1:0] align_q, lead_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      align_q <= SEED;
      lead_q  <= LEAD_SEED;
    end else if (step) begin
      align_q <= prbs_step(align_q);
      lead_q  <= prbs_step(lead_q);
    end
  end

  assign align_bits = align_q[OUT_BITS-1:0];
  assign lead_bits  = lead_q[OUT_BITS-1:0];
endmodule

// File: rtl/cdr_datapath.sv
module cdr_datapath #(
  parameter int IN_W   = 16,
  parameter int DITH_W = 10,
  parameter int OFF_W  = 14,
  parameter int GAIN_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IN_W-1:0]   in_sample,
  input  logic                     chop,
  input  logic signed [DITH_W-1:0] dith,
  input  logic signed [OFF_W-1:0]  offset_trim,
  input  logic [GAIN_W-1:0]        gain_trim,
  output logic                     res_valid,
  output logic signed [IN_W+1:0]   res_value,
  output logic signed [DITH_W-1:0] res_dith,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_sample
);
  localparam int TW   = IN_W + 2;
  localparam int VW   = TW + 1;
  localparam int PW   = VW + GAIN_W + 1;
  localparam int FRAC = GAIN_W - 1;
  localparam logic signed [PW-1:0] HI   = PW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [PW-1:0] LO   = -HI - PW'(1);
  localparam logic signed [PW-1:0] HALF = PW'(2 ** (FRAC - 1));

  // stage A: dither removal and offset trim
  logic                     va;
  logic                     ca;
  logic signed [TW-1:0]     ta;
  logic signed [DITH_W-1:0] da;
  logic signed [TW-1:0]     t_calc;

  assign t_calc = TW'(in_sample) - TW'(dith) + TW'(offset_trim);

  always_ff @(posedge clk) begin
    if (rst) begin
      va <= 1'b0;
      ca <= 1'b0;
      ta <= '0;
      da <= '0;
    end else begin
      va <= in_valid;
      if (in_valid) begin
        ca <= chop;
        ta <= t_calc;
        da <= dith;
      end
    end
  end

  // stage B: sign restore and gain product
  logic                 vb;
  logic signed [PW-1:0] pb;
  logic signed [VW-1:0] v_un;
  logic signed [PW-1:0] g_ext;

  assign v_un  = ca ? -VW'(ta) : VW'(ta);
  assign g_ext = PW'($signed({1'b0, gain_trim}));

  always_ff @(posedge clk) begin
    if (rst) begin
      vb <= 1'b0;
      pb <= '0;
    end else begin
      vb <= va;
      if (va) pb <= PW'(v_un) * g_ext;
    end
  end

  // stage C: round half up, then clamp
  logic signed [PW-1:0] rnd;
  assign rnd = (pb + HALF) >>> FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= vb;
      if (vb) begin
        if (rnd > HI)      out_sample <= HI[OUT_W-1:0];
        else if (rnd < LO) out_sample <= LO[OUT_W-1:0];
        else               out_sample <= rnd[OUT_W-1:0];
      end
    end
  end

  assign res_valid = va;
  assign res_value = ta;
  assign res_dith  = da;
endmodule

// File: rtl/cdr_correlator.sv
module cdr_correlator #(
  parameter int TW      = 18,
  parameter int DITH_W  = 10,
  parameter int ACC_LOG = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               res_valid,
  input  logic signed [TW-1:0]               res_value,
  input  logic signed [DITH_W-1:0]           res_dith,
  output logic                               corr_done,
  output logic signed [TW+ACC_LOG-1:0]       corr_offset,
  output logic signed [TW+DITH_W+ACC_LOG-1:0] corr_gain
);
  localparam int OW = TW + ACC_LOG;
  localparam int GW = TW + DITH_W + ACC_LOG;

  logic [ACC_LOG-1:0]   cnt;
  logic signed [OW-1:0] acc_o, sum_o;
  logic signed [GW-1:0] acc_g, sum_g;
  logic signed [TW+DITH_W-1:0] prod;

  assign prod  = (TW + DITH_W)'(res_value) * (TW + DITH_W)'(res_dith);
  assign sum_o = acc_o + OW'(res_value);
  assign sum_g = acc_g + GW'(prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      acc_o       <= '0;
      acc_g       <= '0;
      corr_done   <= 1'b0;
      corr_offset <= '0;
      corr_gain   <= '0;
    end else begin
      corr_done <= 1'b0;
      if (res_valid) begin
        cnt <= cnt + 1'b1;
        if (&cnt) begin
          corr_offset <= sum_o;
          corr_gain   <= sum_g;
          corr_done   <= 1'b1;
          acc_o       <= '0;
          acc_g       <= '0;
        end else begin
          acc_o <= sum_o;
          acc_g <= sum_g;
        end
      end
    end
  end
endmodule

// File: rtl/slice_unchop_corrector.sv
module slice_unchop_corrector
  import cdr_pkg::*;
#(
  parameter int IN_W    = 16,
  parameter int DITH_W  = 10,
  parameter int OFF_W   = 14,
  parameter int GAIN_W  = 16,
  parameter int OUT_W   = 16,
  parameter int ACC_LOG = 16,
  parameter int LEAD    = 2,
  parameter logic [PRBS_W-1:0] CHOP_SEED = 15'h1ACE,
  parameter logic [PRBS_W-1:0] DITH_SEED = 15'h4B3D
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 in_valid,
  input  logic signed [IN_W-1:0]               in_sample,
  input  logic signed [OFF_W-1:0]              offset_trim,
  input  logic [GAIN_W-1:0]                    gain_trim,
  output logic                                 inj_chop,
  output logic signed [DITH_W-1:0]             inj_dither,
  output logic                                 out_valid,
  output logic signed [OUT_W-1:0]              out_sample,
  output logic                                 corr_done,
  output logic signed [IN_W+2+ACC_LOG-1:0]     corr_offset,
  output logic signed [IN_W+2+DITH_W+ACC_LOG-1:0] corr_gain
);
  localparam int TW = IN_W + 2;

  logic                     chop_now;
  logic [DITH_W-1:0]        dith_now;
  logic                     res_valid;
  logic signed [TW-1:0]     res_value;
  logic signed [DITH_W-1:0] res_dith;

  cdr_prbs #(.SEED(CHOP_SEED), .LEAD(LEAD), .OUT_BITS(1)) u_chop_gen (
    .clk(clk), .rst(rst), .step(in_valid),
    .align_bits(chop_now), .lead_bits(inj_chop)
  );

  cdr_prbs #(.SEED(DITH_SEED), .LEAD(LEAD), .OUT_BITS(DITH_W)) u_dith_gen (
    .clk(clk), .rst(rst), .step(in_valid),
    .align_bits(dith_now), .lead_bits(inj_dither)
  );

  cdr_datapath #(
    .IN_W(IN_W), .DITH_W(DITH_W), .OFF_W(OFF_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W)
  ) u_path (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .chop(chop_now), .dith($signed(dith_now)),
    .offset_trim(offset_trim), .gain_trim(gain_trim),
    .res_valid(res_valid), .res_value(res_value), .res_dith(res_dith),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  cdr_correlator #(.TW(TW), .DITH_W(DITH_W), .ACC_LOG(ACC_LOG)) u_corr (
    .clk(clk), .rst(rst),
    .res_valid(res_valid), .res_value(res_value), .res_dith(res_dith),
    .corr_done(corr_done), .corr_offset(corr_offset), .corr_gain(corr_gain)
  );
endmodule

// File: rtl/cdr_checker.sv
module cdr_checker #(
  parameter int DITH_W = 10,
  parameter int GAIN_W = 16,
  parameter int OUT_W  = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [GAIN_W-1:0]        gain_trim,
  input logic                     inj_chop,
  input logic signed [DITH_W-1:0] inj_dither,
  input logic                     out_valid,
  input logic signed [OUT_W-1:0]  out_sample,
  input logic                     corr_done
);
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));

  a_r5_idle_holds_prbs: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(inj_chop) && $stable(inj_dither)));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    corr_done |=> !corr_done);

  a_r3_zero_gain: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(gain_trim, 2) == '0 && $past(in_valid, 3)) |-> out_sample == '0);
endmodule

bind slice_unchop_corrector cdr_checker #(
  .DITH_W(DITH_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .gain_trim(gain_trim),
  .inj_chop(inj_chop), .inj_dither(inj_dither),
  .out_valid(out_valid), .out_sample(out_sample), .corr_done(corr_done)
);

// File: tb/slice_unchop_corrector_test.sv
module slice_unchop_corrector_test;
  localparam int IN_W = 16, DITH_W = 10, OFF_W = 14, GAIN_W = 16, OUT_W = 16;
  localparam int ACC_LOG = 6, LEAD = 3;
  localparam logic [14:0] CSEED = 15'h1ACE, DSEED = 15'h4B3D;
  localparam int OW = IN_W + 2 + ACC_LOG;
  localparam int GW = IN_W + 2 + DITH_W + ACC_LOG;

  logic clk = 0, rst = 1, in_valid = 0;
  logic signed [IN_W-1:0]  in_sample = '0;
  logic signed [OFF_W-1:0] offset_trim = '0;
  logic [GAIN_W-1:0]       gain_trim = 16'h8000;
  logic                    inj_chop;
  logic signed [DITH_W-1:0] inj_dither;
  logic                    out_valid, corr_done;
  logic signed [OUT_W-1:0] out_sample;
  logic signed [OW-1:0]    corr_offset;
  logic signed [GW-1:0]    corr_gain;

  int checks = 0, errors = 0;
  logic [14:0] cs, ds;

  always #10 clk = ~clk;

  slice_unchop_corrector #(
    .IN_W(IN_W), .DITH_W(DITH_W), .OFF_W(OFF_W), .GAIN_W(GAIN_W), .OUT_W(OUT_W),
    .ACC_LOG(ACC_LOG), .LEAD(LEAD), .CHOP_SEED(CSEED), .DITH_SEED(DSEED)
  ) uut (.*);

  function automatic logic [14:0] nx(input logic [14:0] s);
    return {s[13:0], s[14] ^ s[13]};
  endfunction

  function automatic logic [14:0] adv(input logic [14:0] s, input int n);
    logic [14:0] r = s;
    for (int i = 0; i < n; i++) r = nx(r);
    return r;
  endfunction

  function automatic longint dval(input logic [14:0] s);
    logic signed [DITH_W-1:0] d = s[DITH_W-1:0];
    return longint'(d);
  endfunction

  function automatic longint model_out(input longint t, input bit c, input longint g);
    longint v = c ? -t : t;
    longint r = (v * g + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    // R7 reset values
    check("R7 out_valid", out_valid, 0);
    check("R7 corr_done", corr_done, 0);
    check("R7 corr_offset", corr_offset, 0);
    check("R7 inj_chop", inj_chop, adv(CSEED, LEAD) & 1);
    check("R7 inj_dither", inj_dither, dval(adv(DSEED, LEAD)));
    rst = 0;
    cs = CSEED; ds = DSEED;
  endtask

  // one isolated sample; s is the wanted signal, ao an analog offset
  task automatic one_sample(input string req, input longint s, input longint ao,
                            input longint trim, input longint g);
    bit c = cs[0];
    longint d = dval(ds);
    longint x = (c ? -s : s) + d + ao;
    longint exp = model_out(x - d + trim, c, g);
    @(negedge clk);
    in_valid = 1; in_sample = IN_W'(x);
    offset_trim = OFF_W'(trim); gain_trim = GAIN_W'(g);
    @(negedge clk);
    in_valid = 0;
    cs = nx(cs); ds = nx(ds);
    check({req, " not yet valid"}, out_valid, 0);
    @(negedge clk);
    @(negedge clk);
    check({req, " valid at 3"}, out_valid, 1);
    check(req, out_sample, exp);
  endtask

  task automatic t_basic();
    do_reset();
    one_sample("R3 zero signal", 0, 0, 0, 32768);
    one_sample("R1 R3 pos", 1234, 0, 0, 32768);
    one_sample("R1 R3 neg", -7777, 0, 0, 32768);
    one_sample("R3 gain 0.75", 4000, 0, 0, 24576);
    one_sample("R3 zero gain", 9000, 0, 0, 0);
  endtask

  task automatic t_round();
    one_sample("R3 round up", 3, 0, 0, 16384);
    one_sample("R3 round neg", -3, 0, 0, 16384);
  endtask

  task automatic t_sat();
    one_sample("R4 clamp high", 30000, 0, 0, 61440);
    one_sample("R4 clamp low", -30000, 0, 0, 61440);
  endtask

  task automatic t_offset();
    one_sample("R3 offset cancel a", 500, 900, -900, 32768);
    one_sample("R3 offset cancel b", -2500, -1200, 1200, 32768);
    one_sample("R3 offset residual", 100, 300, 0, 32768);
  endtask

  task automatic t_idle();
    logic c0 = inj_chop;
    logic signed [DITH_W-1:0] d0 = inj_dither;
    repeat (5) @(negedge clk);
    check("R5 idle inj_chop", inj_chop, c0);
    check("R5 idle inj_dither", inj_dither, d0);
    // R2 lead relation after many steps
    check("R2 inj_chop lead", inj_chop, adv(cs, LEAD) & 1);
    check("R2 inj_dither lead", inj_dither, dval(adv(ds, LEAD)));
    one_sample("R5 after idle", 321, 0, 0, 32768);
  endtask

  task automatic t_corr();
    longint so = 0, sg = 0;
    int seen = 0;
    do_reset();
    @(negedge clk);
    offset_trim = OFF_W'(-37); gain_trim = 16'h8000;
    for (int k = 0; k < (1 << ACC_LOG); k++) begin
      longint x = longint'(k) * 413 - 12000;
      longint t = x - dval(ds) - 37;
      so += t; sg += t * dval(ds);
      in_valid = 1; in_sample = IN_W'(x);
      cs = nx(cs); ds = nx(ds);
      @(negedge clk);
      if (k < (1 << ACC_LOG) - 1 && corr_done) seen = 2;
    end
    in_valid = 0;
    for (int w = 0; w < 6 && seen == 0; w++) begin
      if (corr_done) seen = 1; else @(negedge clk);
    end
    check("R6 done seen", seen, 1);
    check("R6 offset sum", corr_offset, so);
    check("R6 gain sum", corr_gain, sg);
    @(negedge clk);
    check("R6 done one cycle", corr_done, 0);
    check("R6 result held", corr_offset, so);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_basic();
    t_round();
    t_sat();
    t_offset();
    t_idle();
    t_corr();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule